// File: doc/BRIEF.md
# Nibble-Addressed Serial Command Target

This block is the bus-facing front end of a quad wiper controller. It watches a two-wire serial bus (I2C timing, SCL and SDA) by oversampling both lines with the system clock. It recognises START and STOP conditions and accepts an address byte whose upper nibble is a fixed device type and whose lower nibble must equal four strap inputs. The address byte carries no direction bit. Direction comes from the opcode in the instruction byte that follows. Depending on that opcode, the transfer either ends after the instruction, carries one data byte from the master, or has the block return one byte taken from `rd_data`.

Decoded commands leave through a small registered interface: a one-cycle `cmd_valid` pulse with opcode, register select, wiper select and data. A separate opcode switches the block into a stepping mode. In that mode every SCL high pulse becomes a one-cycle up or down step, chosen by the SDA level. The register controller reports an active stored-register program cycle on `nv_busy`, and the block then stays silent to its address. A low `wp_n` protects the stored registers.

Top module: `nib_i2c_cmd_target`

## Requirements
- R1: The first byte after START is acknowledged (SDA pulled low for the ninth SCL pulse) only when its bits [7:4] equal 4'b0101 and its bits [3:0] equal `strap_addr`. Any other address leaves SDA released, and the rest of the transfer is ignored until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. `sda_pull` only changes while the synchronised SCL is low. A repeated START abandons the unfinished transfer, so no command is issued for it.
- R3: While `nv_busy` is high, a matching address byte is not acknowledged.
- R4: The instruction byte is split into opcode [7:4], register select [3:2] and wiper select [1:0]. The opcodes that are acknowledged are:
  - 4'b1001: read wiper
  - 4'b1010: write wiper
  - 4'b1011: read stored
  - 4'b1100: write stored
  - 4'b1101: stored to wiper
  - 4'b1110: wiper to stored
  - 4'b0001: all stored to wipers
  - 4'b1000: all wipers to stored
  - 4'b0010: step

  Any other opcode is not acknowledged and produces no command.
- R5: A transfer opcode (4'b1101, 4'b1110, 4'b0001, 4'b1000) that is followed by STOP produces exactly one `cmd_valid` pulse, after the STOP, carrying that opcode and its selects.
- R6: For a write opcode (4'b1010, 4'b1100), the data byte is acknowledged, and after STOP one `cmd_valid` pulse carries the opcode, selects and data. A fourth byte is not acknowledged.
- R7: With `wp_n` low, the data byte of write stored (4'b1100) is not acknowledged and no command results. The wiper-to-stored transfers (4'b1110, 4'b1000) are acknowledged, but no command is issued at STOP. Write wiper still completes.
- R8: For a read opcode (4'b1001, 4'b1011), the block sends `rd_data` MSB first as the third byte. If the master acknowledges, it sends `rd_data` again. If the master does not acknowledge, it releases SDA and waits for STOP. A read never pulses `cmd_valid`.
- R9: After the step opcode is acknowledged, each complete SCL high pulse yields one `step_up` pulse if SDA was high when SCL rose, or one `step_dn` pulse if SDA was low. The high pulse that belongs to STOP yields no step. `step_up` and `step_dn` are never high together, and stepping ends at STOP.
- R10: After reset, `sda_pull`, `cmd_valid`, `step_up` and `step_dn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_addr | input | 4 | Strapped device address nibble |
| wp_n | input | 1 | Write protect for stored registers, active low |
| nv_busy | input | 1 | Stored-register program cycle in progress |
| rd_data | input | 8 | Byte returned by read opcodes, chosen by the controller from cmd_op/cmd_reg/cmd_pot |
| cmd_valid | output | 1 | One-cycle pulse: command ready |
| cmd_op | output | 4 | Opcode of the latest instruction |
| cmd_reg | output | 2 | Stored-register select |
| cmd_pot | output | 2 | Wiper select |
| cmd_data | output | 8 | Data byte for write opcodes |
| step_up | output | 1 | One-cycle wiper step toward the high end |
| step_dn | output | 1 | One-cycle wiper step toward the low end |

## Verification
The embedded properties check every cycle that the SDA pull changes only while SCL is low. They also check that an acknowledge of the address never happens against a busy controller or a wrong address nibble. A protected write-stored data byte is never acknowledged, commands appear only right after a STOP, and step pulses are exclusive and come only from stepping mode. Whole-transfer behaviour can only be shown by the bench's scenarios:
- the correct fields and data on the command interface
- suppression of protected transfers
- the byte returned to the master and its repetition on acknowledge
- the net count of up and down steps
- the abandonment of a transfer cut short by a repeated START

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  localparam logic [3:0] OP_GANG_D2W = 4'b0001;
  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [3:0] OP_GANG_W2D = 4'b1000;
  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_STORE = 4'b1011;
  localparam logic [3:0] OP_WR_STORE = 4'b1100;
  localparam logic [3:0] OP_D2W      = 4'b1101;
  localparam logic [3:0] OP_W2D      = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_HOLD
  } phase_e;

  function automatic logic op_is_read(input logic [3:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_STORE);
  endfunction

  function automatic logic op_is_write(input logic [3:0] op);
    return (op == OP_WR_WIPER) || (op == OP_WR_STORE);
  endfunction

  function automatic logic op_is_xfer(input logic [3:0] op);
    return (op == OP_D2W) || (op == OP_W2D) ||
           (op == OP_GANG_D2W) || (op == OP_GANG_W2D);
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return op_is_read(op) || op_is_write(op) || op_is_xfer(op) || (op == OP_STEP);
  endfunction

  function automatic logic op_programs(input logic [3:0] op);
    return (op == OP_WR_STORE) || (op == OP_W2D) || (op == OP_GANG_W2D);
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '1;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bus_cond.sv
module bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cmd_engine.sv
module cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [3:0]        strap_addr,
  input  logic              wp_n,
  input  logic              nv_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_reg,
  output logic [1:0]        cmd_pot,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              step_up,
  output logic              step_dn
);
  phase_e            ph, nxt, go;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sreg;
  logic              in_ack, pend, mack, armed, sdir, byte_ok;

  always_comb begin
    byte_ok = 1'b0;
    go      = PH_HOLD;
    unique case (ph)
      PH_ADDR: begin
        byte_ok = (sreg == {DEV_TYPE, strap_addr}) && !nv_busy;
        go      = PH_INSTR;
      end
      PH_INSTR: begin
        byte_ok = op_known(sreg[7:4]);
        if (op_is_read(sreg[7:4]))       go = PH_RDATA;
        else if (op_is_write(sreg[7:4])) go = PH_WDATA;
        else if (sreg[7:4] == OP_STEP)   go = PH_STEP;
        else                             go = PH_HOLD;
      end
      PH_WDATA: byte_ok = !((cmd_op == OP_WR_STORE) && !wp_n);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; nxt <= PH_IDLE; cnt <= '0; sreg <= '0;
      in_ack <= 1'b0; pend <= 1'b0; mack <= 1'b0; armed <= 1'b0; sdir <= 1'b0;
      sda_pull <= 1'b0; cmd_valid <= 1'b0; step_up <= 1'b0; step_dn <= 1'b0;
      cmd_op <= '0; cmd_reg <= '0; cmd_pot <= '0; cmd_data <= '0;
    end else begin
      cmd_valid <= 1'b0;
      step_up   <= 1'b0;
      step_dn   <= 1'b0;
      if (start_evt) begin
        ph <= PH_ADDR; cnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0;
        pend <= 1'b0; armed <= 1'b0;
      end else if (stop_evt) begin
        ph <= PH_IDLE; in_ack <= 1'b0; sda_pull <= 1'b0;
        pend <= 1'b0; armed <= 1'b0;
        cmd_valid <= pend && (wp_n || !op_programs(cmd_op));
      end else begin
        unique case (ph)
          PH_ADDR, PH_INSTR, PH_WDATA: begin
            if (scl_rise && !in_ack) begin
              sreg <= {sreg[BYTE_W-2:0], sda_s};
              cnt  <= cnt + 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack   <= 1'b0;
              sda_pull <= 1'b0;
              cnt      <= '0;
              ph       <= nxt;
              if (nxt == PH_RDATA) begin
                sreg     <= rd_data;
                sda_pull <= ~rd_data[BYTE_W-1];
              end
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              if (byte_ok) begin
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
                nxt      <= go;
                if (ph == PH_INSTR) begin
                  cmd_op  <= sreg[7:4];
                  cmd_reg <= sreg[3:2];
                  cmd_pot <= sreg[1:0];
                  pend    <= op_is_xfer(sreg[7:4]);
                end
                if (ph == PH_WDATA) begin
                  cmd_data <= sreg;
                  pend     <= 1'b1;
                end
              end else begin
                ph <= PH_HOLD;
              end
            end
          end
          PH_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(BYTE_W)) mack <= ~sda_s;
            end else if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W + 1)) begin
                cnt <= '0;
                if (mack) begin
                  sreg     <= rd_data;
                  sda_pull <= ~rd_data[BYTE_W-1];
                end else begin
                  ph <= PH_HOLD;
                end
              end else if (cnt == CNT_W'(BYTE_W)) begin
                sda_pull <= 1'b0;
              end else begin
                sreg     <= {sreg[BYTE_W-2:0], 1'b0};
                sda_pull <= ~sreg[BYTE_W-2];
              end
            end
          end
          PH_STEP: begin
            if (scl_rise) begin
              sdir  <= sda_s;
              armed <= 1'b1;
            end else if (scl_fall && armed) begin
              armed   <= 1'b0;
              step_up <= sdir;
              step_dn <= ~sdir;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the pull only moves while SCL was low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s));
  // R1: an address acknowledge needs the exact type and strap nibbles
  p_addr_match_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && $past(ph) == PH_ADDR) |-> ($past(sreg) == {DEV_TYPE, $past(strap_addr)}));
  // R3: no address acknowledge while a program cycle runs
  p_busy_silent_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && $past(ph) == PH_ADDR) |-> !$past(nv_busy));
  // R7: protected write-stored data is never acknowledged
  p_wp_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ack) && $past(ph) == PH_WDATA && cmd_op == OP_WR_STORE) |-> $past(wp_n));
  // R5: commands leave only right after STOP
  p_cmd_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(stop_evt));
  // R9: step pulses are exclusive and come only from stepping mode
  p_step_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));
  p_step_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (step_up || step_dn) |-> ($past(ph) == PH_STEP));
endmodule

// File: rtl/nib_i2c_cmd_target.sv
module nib_i2c_cmd_target
  import i2c_cmd_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [3:0]        strap_addr,
  input  logic              wp_n,
  input  logic              nv_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_reg,
  output logic [1:0]        cmd_pot,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              step_up,
  output logic              step_dn
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cmd_engine #(.DEV_TYPE(DEV_TYPE)) u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_addr(strap_addr), .wp_n(wp_n), .nv_busy(nv_busy), .rd_data(rd_data),
    .sda_pull(sda_pull), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
    .step_up(step_up), .step_dn(step_dn)
  );
endmodule

// File: tb/nib_i2c_cmd_target_tb_top.sv
module nib_i2c_cmd_target_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap;
  logic wp_n = 1'b1, nv_busy = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_pull, cmd_valid, step_up, step_dn;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] cmd_data;
  logic sda_line;

  int nchk = 0, nerr = 0, ncmd = 0, nup = 0, ndn = 0, cyc = 0;
  logic [3:0] l_op; logic [1:0] l_reg, l_pot; logic [7:0] l_data;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  nib_i2c_cmd_target dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .strap_addr(strap), .wp_n(wp_n), .nv_busy(nv_busy), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_pot(cmd_pot),
    .cmd_data(cmd_data), .step_up(step_up), .step_dn(step_dn)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      ncmd++; l_op = cmd_op; l_reg = cmd_reg; l_pot = cmd_pot; l_data = cmd_data;
    end
    if (step_up) nup++;
    if (step_dn) ndn++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(3 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic step_pulse(input logic dir);
    sda_m = dir; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  function automatic logic [7:0] my_addr();
    return {4'b0101, strap};
  endfunction

  // full transfer: address, instruction, nd data bytes, STOP
  task automatic xfer(input logic [7:0] ins, input int nd, input logic [7:0] d,
                      output logic aa, output logic ai, output logic ad, output logic ad2);
    i2c_start();
    send_byte(my_addr(), aa);
    send_byte(ins, ai);
    ad = 1'b0; ad2 = 1'b0;
    if (nd > 0) send_byte(d, ad);
    if (nd > 1) send_byte(d ^ 8'hff, ad2);
    i2c_stop();
  endtask

  initial begin
    int s;
    s = $urandom(32'd20250);
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic aa, ai, ad, ad2;
    logic [7:0] b1, b2, d;
    logic [3:0] op;
    logic [1:0] r, p;
    int c0, u0, d0, eu, ed;
    strap = 4'($urandom_range(0, 15));
    tick(10);
    rst = 1'b0;
    tick(4);
    // R10 reset state
    chk("R10 sda_pull", sda_pull, 0);
    chk("R10 cmd_valid", cmd_valid, 0);
    chk("R10 steps", {step_up, step_dn}, 0);

    // R1 wrong strap and wrong type nibble
    c0 = ncmd;
    i2c_start();
    send_byte({4'b0101, strap ^ 4'($urandom_range(1, 15))}, aa);
    send_byte({OP_D2W_TB(), 4'h0}, ai);
    i2c_stop();
    chk("R1 wrong strap ack", aa, 0);
    chk("R1 ignored instr ack", ai, 0);
    i2c_start(); send_byte({4'b0110, strap}, aa); i2c_stop();
    chk("R1 wrong type ack", aa, 0);
    chk("R1 no command", ncmd, c0);

    // R3 busy silence, then R1 positive match
    nv_busy = 1'b1;
    i2c_start(); send_byte(my_addr(), aa); i2c_stop();
    chk("R3 busy ack", aa, 0);
    nv_busy = 1'b0;
    i2c_start(); send_byte(my_addr(), aa); i2c_stop();
    chk("R1 match ack", aa, 1);

    // R4 undefined opcode
    c0 = ncmd;
    xfer(8'h3_5, 0, 8'h00, aa, ai, ad, ad2);
    chk("R4 bad opcode ack", ai, 0);
    chk("R4 bad opcode no cmd", ncmd, c0);

    // R5 random transfers
    for (int k = 0; k < 6; k++) begin
      case ($urandom_range(0, 3))
        0: op = 4'b1101; 1: op = 4'b1110; 2: op = 4'b0001; default: op = 4'b1000;
      endcase
      r = 2'($urandom_range(0, 3));
      p = (op == 4'b0001 || op == 4'b1000) ? 2'b00 : 2'($urandom_range(0, 3));
      c0 = ncmd;
      xfer({op, r, p}, 0, 8'h00, aa, ai, ad, ad2);
      chk("R5 instr ack", ai, 1);
      chk("R5 one command", ncmd, c0 + 1);
      chk("R5 fields", {l_op, l_reg, l_pot}, {op, r, p});
    end

    // R6 random writes, last one with an extra byte
    for (int k = 0; k < 4; k++) begin
      op = $urandom_range(0, 1) ? 4'b1010 : 4'b1100;
      r = (op == 4'b1010) ? 2'b00 : 2'($urandom_range(0, 3));
      p = 2'($urandom_range(0, 3));
      d = 8'($urandom_range(0, 255));
      c0 = ncmd;
      xfer({op, r, p}, (k == 3) ? 2 : 1, d, aa, ai, ad, ad2);
      chk("R6 data ack", ad, 1);
      chk("R6 one command", ncmd, c0 + 1);
      chk("R6 fields and data", {l_op, l_reg, l_pot, l_data}, {op, r, p, d});
      if (k == 3) chk("R6 fourth byte nack", ad2, 0);
    end

    // R7 write protection
    wp_n = 1'b0;
    c0 = ncmd;
    xfer({4'b1100, 2'b10, 2'b01}, 1, 8'h5a, aa, ai, ad, ad2);
    chk("R7 protected instr ack", ai, 1);
    chk("R7 protected data nack", ad, 0);
    xfer({4'b1110, 2'b01, 2'b11}, 0, 8'h00, aa, ai, ad, ad2);
    chk("R7 protected xfer ack", ai, 1);
    chk("R7 no protected cmd", ncmd, c0);
    xfer({4'b1010, 2'b00, 2'b10}, 1, 8'hc3, aa, ai, ad, ad2);
    chk("R7 wiper write allowed", {ad, l_data}, {1'b1, 8'hc3});
    chk("R7 wiper write cmd", ncmd, c0 + 1);
    wp_n = 1'b1;

    // R8 read with master ack then nack
    for (int k = 0; k < 2; k++) begin
      rd_data = 8'($urandom_range(0, 255));
      if (k == 1) rd_data = 8'h7f;
      c0 = ncmd;
      i2c_start();
      send_byte(my_addr(), aa);
      send_byte({(k == 0) ? 4'b1001 : 4'b1011, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))}, ai);
      read_byte(1'b1, b1);
      read_byte(1'b0, b2);
      tick(Q);
      chk("R8 released after nack", sda_pull, 0);
      i2c_stop();
      chk("R8 first byte", b1, rd_data);
      chk("R8 repeated byte", b2, rd_data);
      chk("R8 no command", ncmd, c0);
    end

    // R9 stepping
    u0 = nup; d0 = ndn; eu = 0; ed = 0;
    i2c_start();
    send_byte(my_addr(), aa);
    send_byte({4'b0010, 2'b00, 2'($urandom_range(0, 3))}, ai);
    for (int k = 0; k < 12; k++) begin
      logic dir;
      dir = 1'($urandom_range(0, 1));
      if (dir) eu++; else ed++;
      step_pulse(dir);
    end
    i2c_stop();
    chk("R9 step instr ack", ai, 1);
    chk("R9 up steps", nup - u0, eu);
    chk("R9 down steps", ndn - d0, ed);
    step_pulse(1'b1);
    chk("R9 no step after stop", nup - u0, eu);

    // R2 repeated START abandons the transfer
    c0 = ncmd;
    i2c_start();
    send_byte(my_addr(), aa);
    send_byte({4'b1101, 2'b11, 2'b10}, ai);
    i2c_start();
    send_byte(my_addr(), aa);
    chk("R2 address after restart", aa, 1);
    i2c_stop();
    chk("R2 abandoned no cmd", ncmd, c0);
    xfer({4'b0001, 2'b11, 2'b00}, 0, 8'h00, aa, ai, ad, ad2);
    chk("R2 next transfer works", {l_op, l_reg}, {4'b0001, 2'b11});

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  function automatic logic [3:0] OP_D2W_TB();
    return 4'b1101;
  endfunction
endmodule